// File: doc/BRIEF.md
# PC Card Bus Access Sequencer

This block bridges an 8-bit host microcontroller bus to a 16-bit PC Card or CompactFlash card. The host programs a handful of byte-wide registers: a 16-bit card address, a 16-bit data word, and a control byte that selects a memory or I/O cycle and a read or write direction. A write to the data low byte launches the card cycle. A hardware sequencer then drives the card. It asserts both chip enables and, for writes, the data drivers. After a setup delay it pulses exactly one strobe. It keeps that strobe active while the card holds WAIT, then releases the strobe and, one clock later, the chip enables.

The host polls a busy and a done bit in the control register to learn when the card cycle has ended. For a read, the card's word is captured into the data registers and read back through them. If the card holds WAIT for too long, a timeout aborts the cycle, releases every strobe and raises an error flag next to done.

Top module: `pccard_seq_bridge`

## Requirements
- R1: With `host_ctl_sel` low, host offset 0/1 hold the address low/high byte and offset 2/3 the data low/high byte; each written byte reads back unchanged.
- R2: With `host_ctl_sel` high, the control byte is: bit 0 cycle type (1 = I/O, 0 = memory), bit 1 direction (1 = read, 0 = write), bit 2 busy, bit 3 done, bit 4 error, bits 7..5 read as zero; only bits 1..0 are writable.
- R3: A write to offset 2 with `host_ctl_sel` low while idle starts a card cycle, and busy reads 1 on the next clock; writes to offsets 0, 1, 3 or the control byte start nothing.
- R4: After reset all six card controls are high, `card_data_oe` is low and every host register reads zero.
- R5: CE1 and CE2 always switch together and are low for exactly 2 clocks before the strobe goes low.
- R6: Exactly one strobe pulses per cycle: WE for a memory write, IOWR for an I/O write, OE for a memory read, IORD for an I/O read.
- R7: The strobe stays low for at least 3 clocks. WAIT (`card_wait_n` low) is sampled only from the third strobe clock on, and the strobe ends on the first such clock where WAIT is released. A card holding WAIT for W strobe clocks gives a strobe of max(3, W+1) clocks.
- R8: After the strobe rises, the chip enables stay low for exactly 1 clock; then they rise, busy clears and done sets.
- R9: In a write cycle `card_data_oe` is high for the whole chip-enable period, while `card_addr` shows the address word and `card_data_out` the data word. In a read cycle `card_data_oe` stays low.
- R10: A read cycle captures `card_data_in` on the clock where the strobe is removed, and the captured word reads back at offsets 2/3.
- R11: If WAIT is still asserted after 256 sampled strobe clocks, the strobe is released after 258 clocks and error and done both set. An aborted read leaves the data registers unchanged.
- R12: Host writes made while busy are ignored: no second cycle starts and the address, data and control bits keep their values.
- R13: Starting a new cycle clears done and error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe, one clock per byte |
| host_ctl_sel | input | 1 | Selects the control/status byte instead of the word registers |
| host_addr | input | 2 | Byte offset inside the register window |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the selected register |
| card_addr | output | 16 | Card address word |
| card_data_out | output | 16 | Data word driven toward the card |
| card_data_oe | output | 1 | Enables the card data drivers |
| card_data_in | input | 16 | Data word driven by the card |
| card_wait_n | input | 1 | Card WAIT, active low |
| card_ce1_n | output | 1 | Chip enable 1, active low |
| card_ce2_n | output | 1 | Chip enable 2, active low |
| card_oe_n | output | 1 | Memory read strobe, active low |
| card_we_n | output | 1 | Memory write strobe, active low |
| card_iord_n | output | 1 | I/O read strobe, active low |
| card_iowr_n | output | 1 | I/O write strobe, active low |

## Verification
The hardest cases to reach from the ports are the edges of the WAIT window. One is a card that releases WAIT on the very last sampled clock before the timeout. The other is a card that never releases it. Both need WAIT held for a precisely counted number of strobe clocks. The bench's card model therefore counts strobe clocks at each falling edge and holds `card_wait_n` low for a programmed count W. Directed runs with W = 257 and W = 1000 separate the last legal stretch from the abort. Host writes are also injected in the middle of a long stretched cycle to show that they are ignored.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETUP  = 2'd1,
    SQ_STROBE = 2'd2,
    SQ_HOLD   = 2'd3
  } sq_state_t;

  localparam int CTL_IO_BIT   = 0;
  localparam int CTL_RD_BIT   = 1;
  localparam int CTL_BUSY_BIT = 2;
  localparam int CTL_DONE_BIT = 3;
  localparam int CTL_ERR_BIT  = 4;

  typedef struct packed {
    logic rd;
    logic io;
  } cyc_kind_t;
endpackage

// File: rtl/pcb_rst_sync.sv
`timescale 1ns/1ps
module pcb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/pcb_host_regs.sv
`timescale 1ns/1ps
module pcb_host_regs
  import pcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_ctl_sel,
  input  logic [1:0]        host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              err,
  input  logic              cap_valid,
  input  logic [WORD_W-1:0] cap_data,
  output logic              start,
  output cyc_kind_t         kind,
  output logic [WORD_W-1:0] addr_word,
  output logic [WORD_W-1:0] data_word
);
  localparam int HI_W = WORD_W - 8;

  logic              wr_ok;
  logic              wr_word;
  logic              addr_lo_en, addr_hi_en, data_lo_en, data_hi_en, kind_en;
  logic [WORD_W-1:0] addr_q, data_q;
  cyc_kind_t         kind_q;

  assign wr_ok   = host_wr && !busy;
  assign wr_word = wr_ok && !host_ctl_sel;

  assign addr_lo_en = wr_word && (host_addr == 2'd0);
  assign addr_hi_en = wr_word && (host_addr == 2'd1);
  assign data_lo_en = wr_word && (host_addr == 2'd2);
  assign data_hi_en = wr_word && (host_addr == 2'd3);
  assign kind_en    = wr_ok && host_ctl_sel;
  assign start      = data_lo_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      if (addr_lo_en) addr_q[7:0]        <= host_wdata;
      if (addr_hi_en) addr_q[WORD_W-1:8] <= host_wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_valid) begin
      data_q <= cap_data;
    end else begin
      if (data_lo_en) data_q[7:0]        <= host_wdata;
      if (data_hi_en) data_q[WORD_W-1:8] <= host_wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
    end else if (kind_en) begin
      kind_q.rd <= host_wdata[CTL_RD_BIT];
      kind_q.io <= host_wdata[CTL_IO_BIT];
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_ctl_sel) begin
      host_rdata[CTL_IO_BIT]   = kind_q.io;
      host_rdata[CTL_RD_BIT]   = kind_q.rd;
      host_rdata[CTL_BUSY_BIT] = busy;
      host_rdata[CTL_DONE_BIT] = done;
      host_rdata[CTL_ERR_BIT]  = err;
    end else begin
      case (host_addr)
        2'd0:    host_rdata = addr_q[7:0];
        2'd1:    host_rdata = addr_q[WORD_W-1:8];
        2'd2:    host_rdata = data_q[7:0];
        default: host_rdata = data_q[WORD_W-1:8];
      endcase
    end
  end

  assign kind      = kind_q;
  assign addr_word = addr_q;
  assign data_word = data_q;

  // R12
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr) |=> $stable(addr_q));

  // R12
  kind_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr) |=> $stable(kind_q));
endmodule

// File: rtl/pcb_seq.sv
`timescale 1ns/1ps
module pcb_seq
  import pcb_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int STROBE_MIN = 3,
  parameter int HOLD_CLKS  = 1,
  parameter int WAIT_LIMIT = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cyc_kind_t         kind,
  input  logic              card_wait_n,
  input  logic [WORD_W-1:0] card_data_in,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cap_valid,
  output logic [WORD_W-1:0] cap_data,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              iord_n,
  output logic              iowr_n,
  output logic              data_oe
);
  localparam int CNT_MAX = STROBE_MIN - 1 + WAIT_LIMIT;
  localparam int CW      = $clog2(CNT_MAX + 1);

  sq_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  cyc_kind_t kind_q;
  logic done_q, err_q;
  logic accept, finish, timeout, cap_en;
  logic done_en, err_en, kind_en;
  logic strb;

  assign accept = start && (st_q == SQ_IDLE);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    finish  = 1'b0;
    timeout = 1'b0;
    cap_en  = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (accept) begin
          st_d  = SQ_SETUP;
          cnt_d = '0;
        end
      end
      SQ_SETUP: begin
        if (cnt_q == CW'(SETUP_CLKS - 1)) begin
          st_d  = SQ_STROBE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_STROBE: begin
        if (cnt_q >= CW'(STROBE_MIN - 1) && card_wait_n) begin
          st_d   = SQ_HOLD;
          cnt_d  = '0;
          cap_en = kind_q.rd;
        end else if (cnt_q == CW'(CNT_MAX - 1)) begin
          st_d    = SQ_HOLD;
          cnt_d   = '0;
          timeout = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        if (cnt_q == CW'(HOLD_CLKS - 1)) begin
          st_d   = SQ_IDLE;
          cnt_d  = '0;
          finish = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  assign done_en = accept || finish;
  assign err_en  = accept || timeout;
  assign kind_en = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      kind_q <= '0;
    end else begin
      if (done_en) done_q <= finish;
      if (err_en)  err_q  <= timeout;
      if (kind_en) kind_q <= kind;
    end
  end

  assign strb      = (st_q == SQ_STROBE);
  assign busy      = (st_q != SQ_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign cap_valid = cap_en;
  assign cap_data  = card_data_in;
  assign ce_n      = (st_q == SQ_IDLE);
  assign we_n      = !(strb && !kind_q.rd && !kind_q.io);
  assign iowr_n    = !(strb && !kind_q.rd &&  kind_q.io);
  assign oe_n      = !(strb &&  kind_q.rd && !kind_q.io);
  assign iord_n    = !(strb &&  kind_q.rd &&  kind_q.io);
  assign data_oe   = !ce_n && !kind_q.rd;

  // Checker state: length of the current strobe run.
  logic [CW-1:0] chk_run;
  logic          any_strb;
  assign any_strb = !(we_n && oe_n && iord_n && iowr_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_run <= '0;
    else if (any_strb) chk_run <= chk_run + 1'b1;
    else chk_run <= '0;
  end

  // R3
  start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R5
  ce_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_strb) |-> $past(!ce_n));

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!we_n, !oe_n, !iord_n, !iowr_n}));

  // R7
  min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_strb) |-> ($past(chk_run) >= CW'(STROBE_MIN - 1)));

  // R8
  hold_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |-> $past(!any_strb));

  // R9
  drivers_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!ce_n && oe_n && iord_n));

  // R11
  strobe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_strb |-> (chk_run < CW'(CNT_MAX)));
endmodule

// File: rtl/pccard_seq_bridge.sv
`timescale 1ns/1ps
module pccard_seq_bridge
  import pcb_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int STROBE_MIN = 3,
  parameter int HOLD_CLKS  = 1,
  parameter int WAIT_LIMIT = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_ctl_sel,
  input  logic [1:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic [15:0] card_addr,
  output logic [15:0] card_data_out,
  output logic        card_data_oe,
  input  logic [15:0] card_data_in,
  input  logic        card_wait_n,
  output logic        card_ce1_n,
  output logic        card_ce2_n,
  output logic        card_oe_n,
  output logic        card_we_n,
  output logic        card_iord_n,
  output logic        card_iowr_n
);
  logic              srst_n;
  logic              start, busy, done, err, cap_valid, ce_n;
  logic [WORD_W-1:0] cap_data;
  cyc_kind_t         kind;

  pcb_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  pcb_host_regs u_regs (
    .clk          (clk),
    .rst_n        (srst_n),
    .host_wr      (host_wr),
    .host_ctl_sel (host_ctl_sel),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .cap_valid    (cap_valid),
    .cap_data     (cap_data),
    .start        (start),
    .kind         (kind),
    .addr_word    (card_addr),
    .data_word    (card_data_out)
  );

  pcb_seq #(
    .SETUP_CLKS (SETUP_CLKS),
    .STROBE_MIN (STROBE_MIN),
    .HOLD_CLKS  (HOLD_CLKS),
    .WAIT_LIMIT (WAIT_LIMIT)
  ) u_seq (
    .clk          (clk),
    .rst_n        (srst_n),
    .start        (start),
    .kind         (kind),
    .card_wait_n  (card_wait_n),
    .card_data_in (card_data_in),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .cap_valid    (cap_valid),
    .cap_data     (cap_data),
    .ce_n         (ce_n),
    .we_n         (card_we_n),
    .oe_n         (card_oe_n),
    .iord_n       (card_iord_n),
    .iowr_n       (card_iowr_n),
    .data_oe      (card_data_oe)
  );

  assign card_ce1_n = ce_n;
  assign card_ce2_n = ce_n;

  // R5
  ce_pair_chk: assert property (@(posedge clk) disable iff (!srst_n)
    card_ce1_n == card_ce2_n);
endmodule

// File: tb/pccard_seq_bridge_test.sv
`timescale 1ns/1ps
module pccard_seq_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic        host_ctl_sel;
  logic [1:0]  host_addr;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic [15:0] card_addr, card_data_out, card_data_in;
  logic        card_data_oe;
  logic        card_wait_n;
  logic        card_ce1_n, card_ce2_n, card_oe_n, card_we_n, card_iord_n, card_iowr_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // card-side monitor state
  int          wait_cycles = 0;
  int          setup_len, strobe_len, hold_len, strobe_starts;
  bit          in_strobe, oe_seen_read, oe_gap_write, ce_split;
  bit          mon_rd;
  logic [3:0]  seen_kind;
  logic [15:0] seen_addr, seen_wdata;

  pccard_seq_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_ctl_sel(host_ctl_sel),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .card_addr(card_addr), .card_data_out(card_data_out), .card_data_oe(card_data_oe),
    .card_data_in(card_data_in), .card_wait_n(card_wait_n),
    .card_ce1_n(card_ce1_n), .card_ce2_n(card_ce2_n), .card_oe_n(card_oe_n),
    .card_we_n(card_we_n), .card_iord_n(card_iord_n), .card_iowr_n(card_iowr_n)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] card_word(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5AC3;
  endfunction

  function automatic int exp_len(input int w);
    if (w >= 258) return 258;
    return (w + 1 > 3) ? w + 1 : 3;
  endfunction

  // strobe code {WE, IOWR, OE, IORD} active bits
  function automatic logic [3:0] exp_kind(input bit io, input bit rd);
    if (!rd && !io) return 4'b1000;
    if (!rd &&  io) return 4'b0100;
    if ( rd && !io) return 4'b0010;
    return 4'b0001;
  endfunction

  assign card_data_in = card_word(card_addr);

  always @(negedge clk) begin
    logic [3:0] act;
    act = {!card_we_n, !card_iowr_n, !card_oe_n, !card_iord_n};
    if (card_ce1_n != card_ce2_n) ce_split = 1;
    if (!card_ce1_n) begin
      if (act != 4'b0) begin
        strobe_len++;
        if (!in_strobe) begin
          strobe_starts++;
          seen_kind = act;
        end
        in_strobe = 1;
        seen_addr  = card_addr;
        seen_wdata = card_data_out;
      end else if (strobe_starts == 0) begin
        setup_len++;
      end else begin
        hold_len++;
      end
      if (!mon_rd && !card_data_oe) oe_gap_write = 1;
    end
    if (act == 4'b0) in_strobe = 0;
    if (mon_rd && card_data_oe) oe_seen_read = 1;
    card_wait_n <= !((act != 4'b0) && (strobe_len <= wait_cycles));
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hw(input bit sel, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_ctl_sel = sel; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic hr(input bit sel, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_ctl_sel = sel; host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic mon_clear(input bit rd, input int w);
    wait_cycles = w; mon_rd = rd;
    setup_len = 0; strobe_len = 0; hold_len = 0; strobe_starts = 0;
    in_strobe = 0; oe_seen_read = 0; oe_gap_write = 0; ce_split = 0;
    seen_kind = 4'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    int guard;
    guard = 0;
    do begin hr(1, 2'd0, st); guard++; end while (st[2] && guard < 600);
  endtask

  task automatic check_cycle(input bit io, input bit rd, input logic [15:0] a,
                             input logic [15:0] d, input int w);
    logic [7:0] st, lo, hi;
    bit to;
    to = (w >= 258);
    hr(1, 2'd0, st);
    chk(st[3] == 1'b1, "R8", "done bit", st[3], 1);
    chk(st[2] == 1'b0, "R8", "busy clear", st[2], 0);
    chk(st[4] == to, "R11", "error bit", st[4], to);
    chk(st[1:0] == {rd, io}, "R2", "kind bits", st[1:0], {rd, io});
    chk(card_ce1_n && card_we_n && card_oe_n && card_iord_n && card_iowr_n,
        "R8", "controls idle", card_ce1_n, 1);
    chk(setup_len == 2 && !ce_split, "R5", "setup clocks", setup_len, 2);
    chk(strobe_starts == 1, "R6", "strobe pulses", strobe_starts, 1);
    chk(seen_kind == exp_kind(io, rd), "R6", "strobe select", seen_kind, exp_kind(io, rd));
    chk(strobe_len == exp_len(w), to ? "R11" : "R7", "strobe length", strobe_len, exp_len(w));
    chk(hold_len == 1, "R8", "hold clocks", hold_len, 1);
    hr(0, 2'd2, lo); hr(0, 2'd3, hi);
    if (rd) begin
      chk(!oe_seen_read, "R9", "drivers off on read", oe_seen_read, 0);
      chk({hi, lo} == (to ? d : card_word(a)), to ? "R11" : "R10", "read data",
          {hi, lo}, to ? d : card_word(a));
    end else begin
      chk(!oe_gap_write, "R9", "drivers on for write", oe_gap_write, 0);
      chk(seen_addr == a && seen_wdata == d, "R9", "card address/data",
          {seen_addr, seen_wdata}, {a, d});
      chk({hi, lo} == d, "R1", "data readback", {hi, lo}, d);
    end
  endtask

  task automatic launch(input bit io, input bit rd, input logic [15:0] a,
                        input logic [15:0] d, input int w);
    logic [7:0] st;
    mon_clear(rd, w);
    hw(1, 2'd0, {6'b0, rd, io});
    hw(0, 2'd1, a[15:8]); hw(0, 2'd0, a[7:0]);
    hw(0, 2'd3, d[15:8]); hw(0, 2'd2, d[7:0]);
    hr(1, 2'd0, st);
    chk(st[2] == 1'b1, "R3", "busy after start", st[2], 1);
    chk(st[3] == 1'b0 && st[4] == 1'b0, "R13", "done/error cleared", st[4:3], 0);
  endtask

  task automatic run_cycle(input bit io, input bit rd, input logic [15:0] a,
                           input logic [15:0] d, input int w);
    launch(io, rd, a, d, w);
    wait_idle();
    check_cycle(io, rd, a, d, w);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, b0, b1, b3;
    void'($urandom(32'h1D2C_3B4A));
    rst_n = 0; host_wr = 0; host_ctl_sel = 0; host_addr = 0; host_wdata = 0;
    mon_clear(0, 0);
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R4 reset state
    chk(card_ce1_n && card_ce2_n && card_we_n && card_oe_n && card_iord_n && card_iowr_n,
        "R4", "controls high", {card_ce1_n, card_we_n}, 3);
    chk(card_data_oe == 1'b0, "R4", "drivers off", card_data_oe, 0);
    hr(1, 2'd0, v); chk(v == 8'h00, "R4", "control byte", v, 0);
    hr(0, 2'd2, v); chk(v == 8'h00, "R4", "data low", v, 0);

    // R2 only kind bits writable
    hw(1, 2'd0, 8'hFF);
    hr(1, 2'd0, v); chk(v == 8'h03, "R2", "writable bits", v, 8'h03);

    // R1 / R3 byte writes that must not start
    mon_clear(0, 0);
    hw(0, 2'd0, 8'h3C); hw(0, 2'd1, 8'hA7); hw(0, 2'd3, 8'h91); hw(1, 2'd0, 8'h00);
    hr(0, 2'd0, b0); hr(0, 2'd1, b1); hr(0, 2'd3, b3);
    chk({b1, b0, b3} == 24'hA73C91, "R1", "byte readback", {b1, b0, b3}, 24'hA73C91);
    hr(1, 2'd0, v);
    chk(v[2] == 1'b0 && card_ce1_n && setup_len == 0, "R3", "no start", v, 0);

    // directed cycles: each type and direction
    run_cycle(0, 0, 16'h1234, 16'hBEEF, 0);
    run_cycle(1, 0, 16'h03F8, 16'h00A5, 5);
    run_cycle(0, 1, 16'h2000, 16'h1111, 2);
    run_cycle(1, 1, 16'h03FA, 16'h2222, 7);
    // WAIT boundaries (R7)
    run_cycle(0, 0, 16'h0001, 16'h0F0F, 3);
    run_cycle(1, 1, 16'h8001, 16'h3333, 257);
    // timeout (R11) then recovery (R13)
    run_cycle(0, 1, 16'h4444, 16'h5566, 1000);
    run_cycle(0, 1, 16'h4444, 16'h5566, 1);

    // R12: writes while busy are ignored
    launch(1, 0, 16'h0ABC, 16'hC0DE, 40);
    repeat (6) @(negedge clk);
    hw(0, 2'd0, 8'h11); hw(0, 2'd1, 8'h22); hw(0, 2'd2, 8'h33); hw(1, 2'd0, 8'h02);
    wait_idle();
    hr(0, 2'd0, b0); hr(0, 2'd1, b1);
    chk({b1, b0} == 16'h0ABC, "R12", "address kept", {b1, b0}, 16'h0ABC);
    check_cycle(1, 0, 16'h0ABC, 16'hC0DE, 40);
    repeat (4) @(negedge clk);
    chk(strobe_starts == 1, "R12", "no second cycle", strobe_starts, 1);

    // constrained random traffic
    for (int i = 0; i < 30; i++) begin
      run_cycle($urandom_range(0, 1), $urandom_range(0, 1),
                16'($urandom), 16'($urandom), $urandom_range(0, 12));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule